// File: doc/BRIEF.md
# Dual-Channel Linear CCD Pixel Stream Classifier

This block sits beside the sampling path of a two-output linear colour CCD. Once per reset-clock period the sampler raises a strobe and presents one sample from each output. The block counts those strobes from a line-start trigger and labels each sample by its place in the fixed readout order. A label is one of black reference, dummy, image pixel or blank feed. Image pixels also get a colour and a pixel number. The first output carries the green row. The second output carries the red/blue row, with red and blue alternating. When the one-line analog delay is in use, the second output's image data belongs to the line before, and the block marks those samples as delayed.

Each line starts with 16 optically shielded samples on each output. The block adds them up and, at the last one, publishes their mean as a black level for each output. Downstream offset correction uses this level. Digitising and colour interpolation are handled elsewhere.

Top module: `ccdpix_stream_classifier`

## Requirements
- R1: While reset is low and in the cycle after it, `tag_valid` and `black_upd` are 0, both kinds are 0 (blank), both colours are 3 (none), the numbers, the data outputs, `ch2_delayed` and both black levels are 0.
- R2: A sample with `sample_strobe` high is tagged in the next cycle, with `tag_valid` high and its data copied to the output. A cycle without a strobe is followed by `tag_valid` low and idle tags: kind 0, colour 3, number 0, data 0, delayed 0.
- R3: The sample position is 0 for a strobe in the same cycle as `line_start`. Otherwise it is one more than the previous strobe's position, saturating at 1046. `line_start` without a strobe makes the next strobe position 0.
- R4: Positions 0 to 15 have kind 1 (black). Channel 1 numbers them 2p+1 (1,3,..,31) and channel 2 numbers them 2p+2 (2,4,..,32). Colour is 3.
- R5: Positions 16,17 and 1042,1043 have kind 2 (dummy) and colour 3. Channel 1 numbers them 1,3,5,7 and channel 2 numbers them 2,4,6,8.
- R6: On channel 1, positions 18 to 1041 have kind 3 (pixel), colour 0 (green) and number p-17 (1 to 1024).
- R7: On channel 2, positions 18 to 1041 have kind 3. Even offsets p-18 are colour 1 (red) and odd offsets are colour 2 (blue). The number is (p-18)/2+1, so the order is R1 B1 R2 B2 up to R512 B512.
- R8: Positions 1044 and above have kind 0 (blank), colour 3 and number 0 on both channels.
- R9: The delay-mode input is captured only in a cycle with `line_start`, and that value applies from that cycle's strobe on. `ch2_delayed` is 1 exactly on tagged channel-2 pixel samples of a line captured in delay mode.
- R10: Each channel's black level is the sum of its samples at positions 0 to 15, shifted right by 4. It loads together with the tag of position 15, `black_upd` pulses high for that one cycle, and the level holds at all other times.
- R11: Sixteen black samples at full scale (all ones) give a black level of full scale, so the sum does not overflow.
- R12: A `line_start` cycle without a strobe produces no tag (`tag_valid` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | Restarts position counting; captures delay mode |
| sample_strobe | input | 1 | One sample per output is present this cycle |
| delay_mode | input | 1 | 1 = one-line delay memory in use |
| ch1_sample | input | SAMPLE_W | Green-row output sample |
| ch2_sample | input | SAMPLE_W | Red/blue-row output sample |
| tag_valid | output | 1 | Tags below describe last cycle's strobe |
| ch1_kind | output | 2 | 0 blank, 1 black, 2 dummy, 3 pixel |
| ch1_color | output | 2 | 0 green, 1 red, 2 blue, 3 none |
| ch1_num | output | NUM_W | Black, dummy or pixel number |
| ch1_data | output | SAMPLE_W | Tagged channel-1 sample |
| ch2_kind | output | 2 | As ch1_kind |
| ch2_color | output | 2 | As ch1_color |
| ch2_num | output | NUM_W | As ch1_num |
| ch2_data | output | SAMPLE_W | Tagged channel-2 sample |
| ch2_delayed | output | 1 | Channel-2 pixel belongs to the previous line |
| black_ch1 | output | SAMPLE_W | Channel-1 black level |
| black_ch2 | output | SAMPLE_W | Channel-2 black level |
| black_upd | output | 1 | Black levels loaded this cycle |

## Verification
Every tag is due exactly one clock after its strobe. The black levels and the update pulse are due in the same cycle as the tag of position 15. A mode captured at line start affects that same cycle's sample. The bench drives inputs on the falling edge and advances its behavioural model at each rising edge using the inputs of that edge. It then compares every output at the next falling edge, so each expectation is checked in the single cycle where it is due. Gaps between strobes, lines that restart part-way through, and positions that run past the end of the line test the counting and the idle tags.

// File: rtl/ccdcls_pkg.sv
// Shared codes for the CCD pixel stream classifier.
// Assumes: two-bit kind and colour fields are decoded downstream by value.
package ccdcls_pkg;

    typedef enum logic [1:0] {
        KIND_BLANK = 2'd0,
        KIND_BLACK = 2'd1,
        KIND_DUMMY = 2'd2,
        KIND_PIXEL = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        COL_GREEN = 2'd0,
        COL_RED   = 2'd1,
        COL_BLUE  = 2'd2,
        COL_NONE  = 2'd3
    } color_e;

endpackage

// File: rtl/ccdcls_pos_ctr.sv
// Position counter: gives the position of the sample in the current cycle.
// Assumes: line_start and strobe are synchronous single-cycle qualifiers.
module ccdcls_pos_ctr #(
    parameter int LINE_PERIODS = 1046,
    parameter int POS_W        = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             strobe,
    output logic [POS_W-1:0] cur_pos
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(LINE_PERIODS);

    logic [POS_W-1:0] cnt_q;

    // Position of this cycle's sample: a restart forces zero.
    assign cur_pos = line_start ? '0 : cnt_q;

    // Advance on each strobe, saturate at the end of the line, clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (strobe) begin
            cnt_q <= (cur_pos >= LAST_POS) ? LAST_POS : cur_pos + 1'b1;
        end else if (line_start) begin
            cnt_q <= '0;
        end
    end

    a_r3_restart_counts_one: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && strobe) |=> (cnt_q == POS_W'(1)));
    a_r3_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_POS);
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && !strobe) |=> $stable(cnt_q));

endmodule

// File: rtl/ccdcls_lane_decode.sv
// Lane decoder: maps a line position to kind, colour and number for one output.
// LANE = 1 is the green output, LANE = 2 the red/blue output.
// Assumes: black, dummy and image spans follow each other in that fixed order.
module ccdcls_lane_decode
    import ccdcls_pkg::*;
#(
    parameter int LANE          = 1,
    parameter int N_BLACK       = 16,
    parameter int N_LEAD_DUMMY  = 2,
    parameter int N_IMAGE       = 1024,
    parameter int N_TRAIL_DUMMY = 2,
    parameter int POS_W         = 11,
    parameter int NUM_W         = 11
) (
    input  logic [POS_W-1:0] pos,
    output kind_e            kind,
    output color_e           color,
    output logic [NUM_W-1:0] num
);
    localparam logic [POS_W-1:0] BLACK_END = POS_W'(N_BLACK);
    localparam logic [POS_W-1:0] LEAD_END  = POS_W'(N_BLACK + N_LEAD_DUMMY);
    localparam logic [POS_W-1:0] IMAGE_END = POS_W'(N_BLACK + N_LEAD_DUMMY + N_IMAGE);
    localparam logic [POS_W-1:0] TRAIL_END = POS_W'(N_BLACK + N_LEAD_DUMMY + N_IMAGE + N_TRAIL_DUMMY);
    localparam logic [NUM_W-1:0] LANE_OFS  = NUM_W'(LANE);
    localparam logic [NUM_W-1:0] TRAIL_OFS = NUM_W'(2 * N_LEAD_DUMMY + LANE);

    logic [POS_W-1:0] off_lead, off_img, off_trail;
    logic [NUM_W-1:0] img_num;
    color_e           img_color;

    // Offsets into each span of the line.
    assign off_lead  = pos - BLACK_END;
    assign off_img   = pos - LEAD_END;
    assign off_trail = pos - IMAGE_END;

    generate
        if (LANE == 1) begin : g_green
            // Green output: one pixel per position.
            assign img_num   = NUM_W'(off_img) + NUM_W'(1);
            assign img_color = COL_GREEN;
        end else begin : g_red_blue
            // Red/blue output: red at even offsets, blue at odd, paired numbering.
            assign img_num   = NUM_W'(off_img >> 1) + NUM_W'(1);
            assign img_color = off_img[0] ? COL_BLUE : COL_RED;
        end
    endgenerate

    // Span selection by position.
    always_comb begin
        kind  = KIND_BLANK;
        color = COL_NONE;
        num   = '0;
        if (pos < BLACK_END) begin
            kind = KIND_BLACK;
            num  = NUM_W'({pos, 1'b0}) + LANE_OFS;
        end else if (pos < LEAD_END) begin
            kind = KIND_DUMMY;
            num  = NUM_W'({off_lead, 1'b0}) + LANE_OFS;
        end else if (pos < IMAGE_END) begin
            kind  = KIND_PIXEL;
            color = img_color;
            num   = img_num;
        end else if (pos < TRAIL_END) begin
            kind = KIND_DUMMY;
            num  = NUM_W'({off_trail, 1'b0}) + TRAIL_OFS;
        end
    end

endmodule

// File: rtl/ccdcls_black_avg.sv
// Black-level averager: sums one output's shielded samples and loads their mean.
// Assumes: N_BLACK is a power of two; position 0 of a line opens a new sum.
module ccdcls_black_avg #(
    parameter int SAMPLE_W = 12,
    parameter int N_BLACK  = 16,
    parameter int POS_W    = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe,
    input  logic [POS_W-1:0]    pos,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SAMPLE_W-1:0] level,
    output logic                upd
);
    localparam int              SHIFT    = $clog2(N_BLACK);
    localparam int              ACC_W    = SAMPLE_W + SHIFT;
    localparam logic [POS_W-1:0] LAST_BLK = POS_W'(N_BLACK - 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   wide_sum;
    logic             in_black;

    // Running sum including this cycle's sample; one spare bit to watch for wrap.
    assign in_black = strobe && (pos <= LAST_BLK);
    assign wide_sum = ((pos == '0) ? '0 : {1'b0, acc_q}) + (ACC_W + 1)'(sample);

    // Accumulate shielded samples and publish the mean at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            level <= '0;
            upd   <= 1'b0;
        end else begin
            upd <= 1'b0;
            if (in_black) begin
                acc_q <= wide_sum[ACC_W-1:0];
                if (pos == LAST_BLK) begin
                    level <= wide_sum[ACC_W-1:SHIFT];
                    upd   <= 1'b1;
                end
            end
        end
    end

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        in_black |-> !wide_sum[ACC_W]);
    a_r10_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |-> $stable(level));
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);

endmodule

// File: rtl/ccdpix_stream_classifier.sv
// Top of the two-output CCD pixel stream classifier: counts sample positions,
// tags both outputs one cycle after each strobe and averages black samples.
// Assumes: one strobe per readout period; line_start marks the transfer pulse.
module ccdpix_stream_classifier
    import ccdcls_pkg::*;
#(
    parameter int SAMPLE_W      = 12,
    parameter int N_BLACK       = 16,
    parameter int N_LEAD_DUMMY  = 2,
    parameter int N_IMAGE       = 1024,
    parameter int N_TRAIL_DUMMY = 2,
    parameter int LINE_PERIODS  = 1046,
    parameter int POS_W         = $clog2(LINE_PERIODS + 1),
    parameter int NUM_W         = $clog2(N_IMAGE + 2 * (N_BLACK + N_LEAD_DUMMY + N_TRAIL_DUMMY) + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_start,
    input  logic                sample_strobe,
    input  logic                delay_mode,
    input  logic [SAMPLE_W-1:0] ch1_sample,
    input  logic [SAMPLE_W-1:0] ch2_sample,
    output logic                tag_valid,
    output logic [1:0]          ch1_kind,
    output logic [1:0]          ch1_color,
    output logic [NUM_W-1:0]    ch1_num,
    output logic [SAMPLE_W-1:0] ch1_data,
    output logic [1:0]          ch2_kind,
    output logic [1:0]          ch2_color,
    output logic [NUM_W-1:0]    ch2_num,
    output logic [SAMPLE_W-1:0] ch2_data,
    output logic                ch2_delayed,
    output logic [SAMPLE_W-1:0] black_ch1,
    output logic [SAMPLE_W-1:0] black_ch2,
    output logic                black_upd
);
    localparam int N_LANES = 2;

    logic [POS_W-1:0]    cur_pos;
    logic                mode_q, mode_now;
    logic [SAMPLE_W-1:0] lane_smp   [N_LANES];
    kind_e               lane_kind  [N_LANES];
    color_e              lane_color [N_LANES];
    logic [NUM_W-1:0]    lane_num   [N_LANES];
    logic [SAMPLE_W-1:0] lane_black [N_LANES];
    logic [N_LANES-1:0]  lane_upd;

    kind_e               kind_q  [N_LANES];
    color_e              color_q [N_LANES];
    logic [NUM_W-1:0]    num_q   [N_LANES];
    logic [SAMPLE_W-1:0] data_q  [N_LANES];
    logic                valid_q, delayed_q;

    assign lane_smp[0] = ch1_sample;
    assign lane_smp[1] = ch2_sample;

    ccdcls_pos_ctr #(
        .LINE_PERIODS (LINE_PERIODS),
        .POS_W        (POS_W)
    ) pos_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .strobe     (sample_strobe),
        .cur_pos    (cur_pos)
    );

    generate
        for (genvar g = 0; g < N_LANES; g++) begin : g_lane
            ccdcls_lane_decode #(
                .LANE          (g + 1),
                .N_BLACK       (N_BLACK),
                .N_LEAD_DUMMY  (N_LEAD_DUMMY),
                .N_IMAGE       (N_IMAGE),
                .N_TRAIL_DUMMY (N_TRAIL_DUMMY),
                .POS_W         (POS_W),
                .NUM_W         (NUM_W)
            ) dec_i (
                .pos   (cur_pos),
                .kind  (lane_kind[g]),
                .color (lane_color[g]),
                .num   (lane_num[g])
            );

            ccdcls_black_avg #(
                .SAMPLE_W (SAMPLE_W),
                .N_BLACK  (N_BLACK),
                .POS_W    (POS_W)
            ) blk_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .strobe (sample_strobe),
                .pos    (cur_pos),
                .sample (lane_smp[g]),
                .level  (lane_black[g]),
                .upd    (lane_upd[g])
            );

            // Register this lane's tag, or return it to idle without a strobe.
            always_ff @(posedge clk) begin
                if (!rst_n || !sample_strobe) begin
                    kind_q[g]  <= KIND_BLANK;
                    color_q[g] <= COL_NONE;
                    num_q[g]   <= '0;
                    data_q[g]  <= '0;
                end else begin
                    kind_q[g]  <= lane_kind[g];
                    color_q[g] <= lane_color[g];
                    num_q[g]   <= lane_num[g];
                    data_q[g]  <= lane_smp[g];
                end
            end
        end
    endgenerate

    // Delay mode in force for this cycle's sample.
    assign mode_now = line_start ? delay_mode : mode_q;

    // Capture the delay mode once per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (line_start) begin
            mode_q <= delay_mode;
        end
    end

    // Tag-valid flag and the previous-line mark for red/blue pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            delayed_q <= 1'b0;
        end else begin
            valid_q   <= sample_strobe;
            delayed_q <= sample_strobe && mode_now && (lane_kind[1] == KIND_PIXEL);
        end
    end

    assign tag_valid   = valid_q;
    assign ch1_kind    = kind_q[0];
    assign ch1_color   = color_q[0];
    assign ch1_num     = num_q[0];
    assign ch1_data    = data_q[0];
    assign ch2_kind    = kind_q[1];
    assign ch2_color   = color_q[1];
    assign ch2_num     = num_q[1];
    assign ch2_data    = data_q[1];
    assign ch2_delayed = delayed_q;
    assign black_ch1   = lane_black[0];
    assign black_ch2   = lane_black[1];
    assign black_upd   = |lane_upd;

    a_r2_tag_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> tag_valid);
    a_r2_idle_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_strobe |=> (!tag_valid && ch1_kind == 2'd0 && ch2_kind == 2'd0));
    a_r9_delay_only_on_pixels: assert property (@(posedge clk) disable iff (!rst_n)
        ch2_delayed |-> (tag_valid && ch2_kind == 2'd3));
    a_r6_green_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_valid && ch1_kind == 2'd3) |-> (ch1_color == 2'd0));
    a_r10_update_at_last_black: assert property (@(posedge clk) disable iff (!rst_n)
        black_upd |-> (tag_valid && ch1_kind == 2'd1 && ch1_num == NUM_W'(2 * N_BLACK - 1)));

endmodule

// File: tb/ccdpix_stream_classifier_tb.sv
// Bench: behavioural per-cycle model of positions, tags and black levels,
// compared with every output on each falling edge.
module ccdpix_stream_classifier_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SW         = 12;
    localparam int NW         = 11;
    localparam int MASK       = (1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst_n, ls, st, dm;
    logic [SW-1:0] d1, d2;
    logic          tag_valid, ch2_delayed, black_upd;
    logic [1:0]    ch1_kind, ch1_color, ch2_kind, ch2_color;
    logic [NW-1:0] ch1_num, ch2_num;
    logic [SW-1:0] ch1_data, ch2_data, black_ch1, black_ch2;

    int n_cmp  = 0;
    int n_fail = 0;
    string scen = "R1";

    // model state
    int m_pos = 0, m_mode = 0, m_s1 = 0, m_s2 = 0;
    int e_valid, e_k1, e_c1, e_n1, e_d1, e_k2, e_c2, e_n2, e_d2, e_del, e_b1, e_b2, e_upd;
    string e_r1, e_r2;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ccdpix_stream_classifier dut_i (
        .clk (clk), .rst_n (rst_n), .line_start (ls), .sample_strobe (st),
        .delay_mode (dm), .ch1_sample (d1), .ch2_sample (d2),
        .tag_valid (tag_valid), .ch1_kind (ch1_kind), .ch1_color (ch1_color),
        .ch1_num (ch1_num), .ch1_data (ch1_data), .ch2_kind (ch2_kind),
        .ch2_color (ch2_color), .ch2_num (ch2_num), .ch2_data (ch2_data),
        .ch2_delayed (ch2_delayed), .black_ch1 (black_ch1), .black_ch2 (black_ch2),
        .black_upd (black_upd)
    );

    // Expected tag for a lane (1 green, 2 red/blue) at position p.
    task automatic ref_tag(input int lane, input int p, output int k, output int c,
                           output int n, output string r);
        k = 0; c = 3; n = 0; r = "R8";
        if (p < 16) begin
            k = 1; n = 2 * p + lane; r = "R4";
        end else if (p == 16 || p == 17) begin
            k = 2; n = 2 * (p - 16) + lane; r = "R5";
        end else if (p >= 1042 && p <= 1043) begin
            k = 2; n = 4 + 2 * (p - 1042) + lane; r = "R5";
        end else if (p >= 18 && p < 1042) begin
            k = 3;
            if (lane == 1) begin
                c = 0; n = p - 17; r = "R6";
            end else begin
                c = ((p - 18) % 2 == 0) ? 1 : 2; n = (p - 18) / 2 + 1; r = "R7";
            end
        end
    endtask

    // Advance the model by one rising edge with the inputs present at it.
    task automatic model_edge();
        int p, mode_now;
        e_upd = 0;
        if (!rst_n) begin
            m_pos = 0; m_mode = 0; m_s1 = 0; m_s2 = 0;
            e_valid = 0; e_k1 = 0; e_c1 = 3; e_n1 = 0; e_d1 = 0;
            e_k2 = 0; e_c2 = 3; e_n2 = 0; e_d2 = 0; e_del = 0; e_b1 = 0; e_b2 = 0;
            e_r1 = "R1"; e_r2 = "R1";
            return;
        end
        mode_now = ls ? int'(dm) : m_mode;
        if (ls) m_mode = int'(dm);
        if (st) begin
            p = ls ? 0 : m_pos;
            m_pos = (p + 1 > 1046) ? 1046 : p + 1;
            ref_tag(1, p, e_k1, e_c1, e_n1, e_r1);
            ref_tag(2, p, e_k2, e_c2, e_n2, e_r2);
            e_valid = 1; e_d1 = int'(d1); e_d2 = int'(d2);
            e_del = (mode_now != 0 && e_k2 == 3) ? 1 : 0;
            if (p < 16) begin
                m_s1 = ((p == 0) ? 0 : m_s1) + int'(d1);
                m_s2 = ((p == 0) ? 0 : m_s2) + int'(d2);
                if (p == 15) begin
                    e_b1 = m_s1 / 16; e_b2 = m_s2 / 16; e_upd = 1;
                end
            end
        end else begin
            if (ls) m_pos = 0;
            e_valid = 0; e_k1 = 0; e_c1 = 3; e_n1 = 0; e_d1 = 0;
            e_k2 = 0; e_c2 = 3; e_n2 = 0; e_d2 = 0; e_del = 0;
            e_r1 = "R2"; e_r2 = "R2";
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (scenario %s) %s act=%0d exp=%0d at %0t",
                     req, scen, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(rst_n ? "R2" : "R1", "tag_valid", int'(tag_valid), e_valid);
        chk(e_r1, "ch1_kind", int'(ch1_kind), e_k1);
        chk(e_r1, "ch1_color", int'(ch1_color), e_c1);
        chk(e_r1, "ch1_num", int'(ch1_num), e_n1);
        chk("R2", "ch1_data", int'(ch1_data), e_d1);
        chk(e_r2, "ch2_kind", int'(ch2_kind), e_k2);
        chk(e_r2, "ch2_color", int'(ch2_color), e_c2);
        chk(e_r2, "ch2_num", int'(ch2_num), e_n2);
        chk("R2", "ch2_data", int'(ch2_data), e_d2);
        chk("R9", "ch2_delayed", int'(ch2_delayed), e_del);
        chk("R10", "black_ch1", int'(black_ch1), e_b1);
        chk("R10", "black_ch2", int'(black_ch2), e_b2);
        chk("R10", "black_upd", int'(black_upd), e_upd);
    endtask

    // One cycle: drive at the falling edge, model at the rising edge, compare at the next falling edge.
    task automatic step(input logic r, input logic l, input logic s, input logic m,
                        input int a, input int b);
        rst_n = r; ls = l; st = s; dm = m;
        d1 = SW'(a & MASK); d2 = SW'(b & MASK);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ls = 1'b0; st = 1'b0; dm = 1'b0; d1 = '0; d2 = '0;
        @(negedge clk);
        // R1: reset state holds even with strobes present
        scen = "R1";
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b1, 4095, 4095);
        step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0);

        // R6: full line, no delay, varied data, run past the end (R8 saturation)
        scen = "R6";
        step(1'b1, 1'b1, 1'b1, 1'b0, 5, 77);
        for (int i = 1; i < 1052; i++)
            step(1'b1, 1'b0, 1'b1, 1'b0, i * 37 + 5, int'($urandom));

        // R12: restart without a strobe, delay mode on, strobes every other cycle,
        // mode input flipped mid-line (R9), full-scale black samples (R11)
        scen = "R12";
        step(1'b1, 1'b1, 1'b0, 1'b1, 0, 0);
        for (int i = 0; i < 2104; i++)
            step(1'b1, 1'b0, (i % 2 == 0), (i < 300), 4095, 4095);

        // R3: restart part-way through a line, then a delayed line
        scen = "R3";
        step(1'b1, 1'b1, 1'b1, 1'b0, 100, 200);
        for (int i = 0; i < 500; i++)
            step(1'b1, 1'b0, 1'b1, 1'b0, int'($urandom), int'($urandom));
        step(1'b1, 1'b1, 1'b1, 1'b1, 300, 400);
        for (int i = 0; i < 1050; i++)
            step(1'b1, 1'b0, (i % 7 != 3), 1'b0, int'($urandom), int'($urandom));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule